// File: doc/BRIEF.md
# Opcode Row Sequencer for an 8-bit CPU

This block fetches and executes the first sixteen opcodes (0x00 to 0x0F) of an 8-bit processor. It holds the accumulator A, the general registers B, C, H and L, the stack pointer SP, the program counter PC and the flag byte. It talks to memory over a synchronous byte-wide bus that allows one access per cycle: the block drives an address, write data and a write enable, and the read data for an address arrives in the next cycle.

Each instruction starts with an opcode fetch from PC. The block then fetches any immediate bytes and performs the register or memory effect. It raises `instr_done` for one cycle in the cycle after the instruction's final effect commits, and it returns to fetch. Register pair operations (16-bit increment and decrement, the wide add into HL, and the SP store) sit beside 8-bit arithmetic and rotates, and the two groups follow different flag rules. Register state is visible on output ports so that the surrounding core and the bench can observe it.

Flag byte layout: Z is bit 7, N is bit 6, H (half carry) is bit 5 and C (carry) is bit 4. Bits 3 to 0 read as zero.

Top module: `opc_row_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets PC to 0x0000, A to `RST_A`, HL to `RST_HL` and SP to `RST_SP`, and clears B, C and the flags. It also holds `instr_done` and `mem_we` low.
- R2: Every opcode and immediate byte is read from the address in PC, and PC advances by one past each of these bytes. `instr_done` is a one-cycle pulse. The cycles from fetch to `instr_done` are 4 for 0x01, 5 for 0x08, 3 for 0x06, 0x0E and 0x0A, and 2 for every other opcode, including 0x00 (which has no effect).
- R3: 0x01 loads a 16-bit immediate into BC, with the low byte first (C gets the first byte and B the second). 0x06 loads the next byte into B, and 0x0E loads it into C. Flags are unchanged.
- R4: 0x02 writes A to the address held in BC. 0x0A reads the byte at the address held in BC into A. Flags are unchanged.
- R5: 0x03 adds one to BC and 0x0B subtracts one from BC. Both work on the full 16 bits, wrap modulo 65536 and leave all four flags unchanged.
- R6: 0x04 increments B and 0x0C increments C. Z is set if the result is zero, N is cleared, H is set when the old low nibble was 0xF, and C is unchanged.
- R7: 0x05 decrements B and 0x0D decrements C. Z is set if the result is zero, N is set, H is set when the old low nibble was 0x0, and C is unchanged.
- R8: 0x07 rotates A left by one, with the old bit 7 going to both bit 0 and C. 0x0F rotates A right by one, with the old bit 0 going to both bit 7 and C. Both clear Z, N and H.
- R9: 0x09 writes HL+BC, modulo 65536, back to HL. It clears N, sets H on a carry out of bit 11, sets C on a carry out of bit 15, and leaves Z unchanged.
- R10: 0x08 fetches a 16-bit address (low byte first). It writes the low byte of SP to that address, then in the next cycle writes the high byte of SP to that address plus one.
- R11: Any opcode above 0x0F takes two cycles and changes nothing but PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address for this cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data for the address presented in the previous cycle |
| instr_done | output | 1 | One-cycle pulse after an instruction completes |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| reg_h | output | 8 | Register H |
| reg_l | output | 8 | Register L |
| reg_sp | output | 16 | Stack pointer |
| reg_pc | output | 16 | Program counter |
| reg_flags | output | 8 | Flags {Z,N,H,C,4'b0} |

## Verification
The bench carries BC across 0x00FF to 0x0100 and from 0xFFFF to 0x0000 and back. A design that dropped the carry between the bytes, or touched the flags, would show a wrong BC or flag byte. It drives INC and DEC through nibble boundaries and through zero while C is set, which catches a half carry taken from the wrong nibble, a Z flag computed from the old value, and a carry flag wrongly overwritten. It runs the wide add once with only a bit-11 carry and once with only a bit-15 carry, so a mix-up between the two carries shows in the flags. It also stores SP to an address and checks both bytes in memory, which exposes a swapped byte order or a missing +1. It counts the cycles of every instruction, so an extra or missing state shows as a wrong count. Finally, it asserts reset in the middle of execution to show that PC and the registers return to their reset values.

// File: rtl/opc_row_seq.sv
module opc_row_seq #(
  parameter logic [7:0]  RST_A  = 8'h00,
  parameter logic [15:0] RST_HL = 16'h0000,
  parameter logic [15:0] RST_SP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic        instr_done,
  output logic [7:0]  reg_a,
  output logic [7:0]  reg_b,
  output logic [7:0]  reg_c,
  output logic [7:0]  reg_h,
  output logic [7:0]  reg_l,
  output logic [15:0] reg_sp,
  output logic [15:0] reg_pc,
  output logic [7:0]  reg_flags
);

  typedef enum logic [2:0] {S_FETCH, S_EXEC, S_IMM_LO, S_IMM_HI, S_READ, S_WR_HI} state_t;

  state_t      state;
  logic [7:0]  a, b, c, h, l, ir, lo;
  logic [15:0] sp, pc, wptr;
  logic        zf, nf, hf, cf, done;

  wire [7:0]  op     = mem_rdata;
  wire [7:0]  tgt    = op[3] ? c : b;
  wire [7:0]  tgt_up = tgt + 8'd1;
  wire [7:0]  tgt_dn = tgt - 8'd1;
  wire [15:0] bc     = {b, c};
  wire [15:0] bc_up  = bc + 16'd1;
  wire [15:0] bc_dn  = bc - 16'd1;
  wire [16:0] hl_sum = {1'b0, h, l} + {1'b0, b, c};
  wire [12:0] hl_mid = {1'b0, h[3:0], l} + {1'b0, b[3:0], c};

  always_comb begin
    mem_addr  = pc;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    case (state)
      S_EXEC: begin
        if (op == 8'h02) begin
          mem_addr  = bc;
          mem_wdata = a;
          mem_we    = 1'b1;
        end else if (op == 8'h0A) begin
          mem_addr = bc;
        end
      end
      S_IMM_HI: begin
        if (ir == 8'h08) begin
          mem_addr  = {mem_rdata, lo};
          mem_wdata = sp[7:0];
          mem_we    = 1'b1;
        end
      end
      S_WR_HI: begin
        mem_addr  = wptr;
        mem_wdata = sp[15:8];
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      a <= RST_A;  b <= 8'h00;  c <= 8'h00;
      {h, l} <= RST_HL;
      sp <= RST_SP;  pc <= 16'h0000;
      zf <= 1'b0;  nf <= 1'b0;  hf <= 1'b0;  cf <= 1'b0;
      ir <= 8'h00;  lo <= 8'h00;  wptr <= 16'h0000;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_FETCH: begin
          pc    <= pc + 16'd1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          ir    <= op;
          state <= S_FETCH;
          done  <= 1'b1;
          case (op)
            8'h01, 8'h08, 8'h06, 8'h0E: begin
              pc    <= pc + 16'd1;
              state <= S_IMM_LO;
              done  <= 1'b0;
            end
            8'h0A: begin
              state <= S_READ;
              done  <= 1'b0;
            end
            8'h03: {b, c} <= bc_up;
            8'h0B: {b, c} <= bc_dn;
            8'h04, 8'h0C: begin
              if (op[3]) c <= tgt_up; else b <= tgt_up;
              zf <= (tgt_up == 8'h00);
              nf <= 1'b0;
              hf <= (tgt[3:0] == 4'hF);
            end
            8'h05, 8'h0D: begin
              if (op[3]) c <= tgt_dn; else b <= tgt_dn;
              zf <= (tgt_dn == 8'h00);
              nf <= 1'b1;
              hf <= (tgt[3:0] == 4'h0);
            end
            8'h07: begin
              a  <= {a[6:0], a[7]};
              cf <= a[7];
              zf <= 1'b0;  nf <= 1'b0;  hf <= 1'b0;
            end
            8'h0F: begin
              a  <= {a[0], a[7:1]};
              cf <= a[0];
              zf <= 1'b0;  nf <= 1'b0;  hf <= 1'b0;
            end
            8'h09: begin
              {h, l} <= hl_sum[15:0];
              nf <= 1'b0;
              hf <= hl_mid[12];
              cf <= hl_sum[16];
            end
            default: ;
          endcase
        end
        S_IMM_LO: begin
          lo <= mem_rdata;
          if (ir == 8'h06) begin
            b <= mem_rdata;  done <= 1'b1;  state <= S_FETCH;
          end else if (ir == 8'h0E) begin
            c <= mem_rdata;  done <= 1'b1;  state <= S_FETCH;
          end else begin
            pc    <= pc + 16'd1;
            state <= S_IMM_HI;
          end
        end
        S_IMM_HI: begin
          if (ir == 8'h01) begin
            b <= mem_rdata;  c <= lo;
            done  <= 1'b1;
            state <= S_FETCH;
          end else begin
            wptr  <= {mem_rdata, lo} + 16'd1;
            state <= S_WR_HI;
          end
        end
        S_READ: begin
          a <= mem_rdata;  done <= 1'b1;  state <= S_FETCH;
        end
        S_WR_HI: begin
          done <= 1'b1;  state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign instr_done = done;
  assign reg_a  = a;
  assign reg_b  = b;
  assign reg_c  = c;
  assign reg_h  = h;
  assign reg_l  = l;
  assign reg_sp = sp;
  assign reg_pc = pc;
  assign reg_flags = {zf, nf, hf, cf, 4'b0000};

  p_reset_pc_r1: assert property (@(posedge clk)
    $past(rst) |-> (reg_pc == 16'h0000 && !instr_done));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> reg_pc == $past(reg_pc) + 16'd1);

  p_pair_flags_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && (mem_rdata == 8'h03 || mem_rdata == 8'h0B)) |=> $stable(reg_flags));

  p_carry_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && mem_rdata[7:4] == 4'h0 && mem_rdata[2:1] == 2'b10)
      |=> reg_flags[4] == $past(reg_flags[4]));

  p_store_hi_r10: assert property (@(posedge clk) disable iff (rst)
    state == S_WR_HI |-> (mem_we && mem_addr == $past(mem_addr) + 16'd1
                          && mem_wdata == $past(reg_sp[15:8])));

endmodule

// File: tb/opc_row_seq_test.sv
`timescale 1ns/1ps
module opc_row_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, instr_done;
  logic [7:0]  reg_a, reg_b, reg_c, reg_h, reg_l, reg_flags;
  logic [15:0] reg_sp, reg_pc;

  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  mem [0:4095];

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  opc_row_seq #(.RST_A(8'h81), .RST_HL(16'h0FFF), .RST_SP(16'h1234)) uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .instr_done(instr_done),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_h(reg_h), .reg_l(reg_l),
    .reg_sp(reg_sp), .reg_pc(reg_pc), .reg_flags(reg_flags));

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  // {op, imm_lo, imm_hi, A, B, C, HL, flags} after each instruction
  localparam int NV = 26;
  localparam logic [71:0] VEC [0:NV-1] = '{
    72'h00_00_00_81_00_00_0FFF_00,
    72'h01_FF_00_81_00_FF_0FFF_00,
    72'h03_00_00_81_01_00_0FFF_00,
    72'h0B_00_00_81_00_FF_0FFF_00,
    72'h0C_00_00_81_00_00_0FFF_A0,
    72'h0D_00_00_81_00_FF_0FFF_60,
    72'h07_00_00_03_00_FF_0FFF_10,
    72'h04_00_00_03_01_FF_0FFF_10,
    72'h05_00_00_03_00_FF_0FFF_D0,
    72'h0F_00_00_81_00_FF_0FFF_10,
    72'h06_0F_00_81_0F_FF_0FFF_10,
    72'h04_00_00_81_10_FF_0FFF_30,
    72'h0E_01_00_81_10_01_0FFF_30,
    72'h09_00_00_81_10_01_2000_20,
    72'h01_00_F0_81_F0_00_2000_20,
    72'h09_00_00_81_F0_00_1000_10,
    72'h01_00_08_81_08_00_1000_10,
    72'h02_00_00_81_08_00_1000_10,
    72'h03_00_00_81_08_01_1000_10,
    72'h0A_00_00_5A_08_01_1000_10,
    72'h08_10_08_5A_08_01_1000_10,
    72'h0B_00_00_5A_08_00_1000_10,
    72'h3E_00_00_5A_08_00_1000_10,
    72'h01_FF_FF_5A_FF_FF_1000_10,
    72'h03_00_00_5A_00_00_1000_10,
    72'h0B_00_00_5A_FF_FF_1000_10
  };

  function automatic int op_len(input logic [7:0] op);
    if (op == 8'h01 || op == 8'h08) return 3;
    if (op == 8'h06 || op == 8'h0E) return 2;
    return 1;
  endfunction

  function automatic int op_cyc(input logic [7:0] op);
    if (op == 8'h01) return 4;
    if (op == 8'h08) return 5;
    if (op == 8'h06 || op == 8'h0E || op == 8'h0A) return 3;
    return 2;
  endfunction

  function automatic string op_req(input logic [7:0] op);
    case (op)
      8'h00: return "R2";
      8'h01, 8'h06, 8'h0E: return "R3";
      8'h02, 8'h0A: return "R4";
      8'h03, 8'h0B: return "R5";
      8'h04, 8'h0C: return "R6";
      8'h05, 8'h0D: return "R7";
      8'h07, 8'h0F: return "R8";
      8'h09: return "R9";
      8'h08: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [7:0] data);
    @(negedge clk);
    ld_en = 1'b1;  ld_addr = addr[11:0];  ld_data = data;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!instr_done && n < 40);
  endtask

  task automatic check_reset_state(input string tag);
    chk(reg_pc == 16'h0000, "R1", {tag, " pc"}, reg_pc, 0);
    chk({reg_a, reg_b, reg_c} == 24'h810000, "R1", {tag, " a/b/c"}, {reg_a, reg_b, reg_c}, 24'h810000);
    chk({reg_h, reg_l} == 16'h0FFF && reg_sp == 16'h1234, "R1", {tag, " hl/sp"},
        {reg_h, reg_l, reg_sp}, 32'h0FFF1234);
    chk(reg_flags == 8'h00 && !instr_done && !mem_we, "R1", {tag, " flags/done/we"},
        {reg_flags, 7'b0, instr_done, 7'b0, mem_we}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int p;
    int pc_exp;
    int n;
    p = 0;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      op = VEC[i][71:64];
      put(p, op);
      if (op_len(op) > 1) put(p + 1, VEC[i][63:56]);
      if (op_len(op) > 2) put(p + 2, VEC[i][55:48]);
      p += op_len(op);
    end
    for (int k = p; k < 64; k++) put(k, 8'h00);
    put(12'h800, 8'h00);
    put(12'h801, 8'h5A);
    put(12'h810, 8'h00);
    put(12'h811, 8'h00);
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    check_reset_state("initial");
    rst = 1'b0;

    pc_exp = 0;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      string rq;
      op = VEC[i][71:64];
      rq = op_req(op);
      pc_exp += op_len(op);
      wait_done(n);
      chk(instr_done, "R2", $sformatf("step %0d done", i), {31'b0, instr_done}, 1);
      chk(n == op_cyc(op), "R2", $sformatf("step %0d cycles op %h", i, op), n, op_cyc(op));
      chk(reg_pc == pc_exp[15:0], rq, $sformatf("step %0d pc", i), reg_pc, pc_exp);
      chk({reg_a, reg_b, reg_c} == VEC[i][47:24], rq, $sformatf("step %0d a/b/c op %h", i, op),
          {reg_a, reg_b, reg_c}, VEC[i][47:24]);
      chk({reg_h, reg_l} == VEC[i][23:8], rq, $sformatf("step %0d hl op %h", i, op),
          {reg_h, reg_l}, VEC[i][23:8]);
      chk(reg_flags == VEC[i][7:0], rq, $sformatf("step %0d flags op %h", i, op),
          reg_flags, VEC[i][7:0]);
    end

    chk(mem[12'h800] == 8'h81, "R4", "store A at BC", mem[12'h800], 8'h81);
    chk(mem[12'h810] == 8'h34, "R10", "SP low byte", mem[12'h810], 8'h34);
    chk(mem[12'h811] == 8'h12, "R10", "SP high byte", mem[12'h811], 8'h12);
    chk(reg_sp == 16'h1234, "R10", "SP unchanged", reg_sp, 16'h1234);

    // reset in the middle of execution
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("mid-run");
    rst = 1'b0;
    wait_done(n);
    chk(n == 2, "R2", "first op after reset cycles", n, 2);
    chk(reg_pc == 16'h0001, "R2", "pc after NOP at 0", reg_pc, 1);
    chk({reg_a, reg_b, reg_c} == 24'h810000, "R2", "NOP keeps regs", {reg_a, reg_b, reg_c}, 24'h810000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule